// File: doc/BRIEF.md
# Dual-Event Performance Monitor Counter

This block counts occurrences of hardware events for performance analysis. Two events are picked from a wide event bus by two 6-bit selectors. A programmable combine mode sets what counts: the first event alone, both events in the same cycle, or exactly one of the two. While counting is enabled, each qualifying cycle advances a main counter by one.

A secondary register sits beside the counter and has three roles. It can stay at zero. It can follow the counter's upper half on every increment, which gives a coarse snapshot. It can also act as a ceiling at which the counter stops. When the counter wraps or reaches its ceiling, a sticky overflow flag is set. If interrupts are enabled, that flag drives the interrupt output.

Software reaches the block through a small synchronous register port. Reads are combinational and writes take effect at the clock edge. Address 0 is the control word, address 1 is the counter and address 2 is the secondary register.

Top module: `perf_event_counter`

## Requirements
- R1: After reset, the control word, the counter and the secondary register all read as zero, and `irq` is low.
- R2: A selector value of 0 means no event and never counts. A value n picks event line `evt_i[n]`, with the first selector in control bits 29:24 and the second in bits 21:16.
- R3: With enable (control bit 0) set and combine mode 000 (bits 6:4), the counter advances by one in each cycle in which the first selected event is high. With enable clear, the counter holds.
- R4: Combine mode 001 counts cycles in which both selected events are high. Mode 010 counts cycles in which exactly one of them is high. Every other mode value counts nothing.
- R5: Outside ceiling mode, an increment from the all-ones value wraps the counter to zero and sets overflow status (control bit 3).
- R6: Overflow status is sticky. It stays set through further counting and through writes to the control word that do not request a clear.
- R7: `irq` is high exactly when overflow status and interrupt enable (control bit 2) are both set.
- R8: A control write with bit 1 set zeroes the counter and overflow status from the next cycle. Bit 1 always reads back as 0.
- R9: In secondary mode 001 (control bits 9:7), every increment copies the upper half of the new counter value into the lower half of the secondary register, and the upper half of that register is zeroed.
- R10: In secondary mode 011, the counter stops at the secondary register's value. An increment requested at or above that value leaves the counter unchanged and sets overflow status.
- R11: In secondary mode 000, the secondary register is held at zero and writes to it are ignored.
- R12: Control bits 31:30, 23:22 and 1 read as zero whatever was written. Bit 3 ignores writes. Bits 15:10 (two stored 3-bit fields, filter select and minimum stall period) read back as written.
- R13: Writes to address 1 do not change the counter. Address 3 reads as zero. The secondary register is writable at address 2 outside modes 000 and 001.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| evt_i | input | EVT_W | Event lines; line 0 is never counted |
| bus_wr | input | 1 | Write strobe for the register port |
| bus_addr | input | 2 | Register address: 0 control, 1 counter, 2 secondary |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Overflow interrupt, level |

## Verification
The assertions check the following on every cycle:
- a clear zeroes the counter and overflow status;
- overflow status never drops without a clear;
- the counter moves by at most one step;
- a disabled counter holds;
- the counter never goes past the ceiling in ceiling mode;
- the secondary register stays at zero in mode 000.

Only the bench scenarios can show that the right event lines are picked, that each combine mode counts the right cycles, the exact wrap at all-ones, the captured snapshot value, and the read-back of every control field through the port.

// File: rtl/pmc_pkg.sv
// Package: shared field positions, mode codes and the configuration record
// for the dual-event performance monitor counter.
// Assumes a 32-bit control word whose layout is seen by software.
package pmc_pkg;

    localparam int unsigned CTRL_W   = 32;
    localparam int unsigned SEL_W    = 6;

    // Bit positions inside the control word (software-visible layout).
    localparam int unsigned B_EN     = 0;
    localparam int unsigned B_CLR    = 1;
    localparam int unsigned B_IE     = 2;
    localparam int unsigned B_OVF    = 3;
    localparam int unsigned B_CMODE  = 4;
    localparam int unsigned B_SMODE  = 7;
    localparam int unsigned B_FILT   = 10;
    localparam int unsigned B_STALL  = 13;
    localparam int unsigned B_SELB   = 16;
    localparam int unsigned B_SELA   = 24;

    // Combine modes for the two selected events.
    typedef enum logic [2:0] {
        CM_FIRST  = 3'b000,
        CM_BOTH   = 3'b001,
        CM_EITHER = 3'b010
    } cmb_mode_e;

    // Roles of the secondary register.
    typedef enum logic [2:0] {
        SM_ZERO = 3'b000,
        SM_SNAP = 3'b001,
        SM_CEIL = 3'b011
    } sec_mode_e;

    // Stored configuration fields.
    typedef struct packed {
        logic [SEL_W-1:0] sel_a;
        logic [SEL_W-1:0] sel_b;
        logic [2:0]       stall;
        logic [2:0]       filt;
        logic [2:0]       smode;
        logic [2:0]       cmode;
        logic             ie;
        logic             en;
    } pmc_cfg_t;

endpackage

// File: rtl/pmc_ctrl_reg.sv
// Module: control register of the monitor counter.
// Stores the writable fields, produces a one-cycle clear request on a write
// with the clear bit set, and assembles the read-back word. Reserved bits and
// the clear bit read as zero; overflow status comes from the counter.
module pmc_ctrl_reg
    import pmc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [CTRL_W-1:0] wdata,
    input  logic              ovf,
    output pmc_cfg_t          cfg,
    output logic              clr_req,
    output logic [CTRL_W-1:0] word
);

    logic unused_bits;

    // Store the writable fields on a control write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= '0;
        end else if (wr) begin
            cfg.en    <= wdata[B_EN];
            cfg.ie    <= wdata[B_IE];
            cfg.cmode <= wdata[B_CMODE +: 3];
            cfg.smode <= wdata[B_SMODE +: 3];
            cfg.filt  <= wdata[B_FILT  +: 3];
            cfg.stall <= wdata[B_STALL +: 3];
            cfg.sel_b <= wdata[B_SELB  +: SEL_W];
            cfg.sel_a <= wdata[B_SELA  +: SEL_W];
        end
    end

    // Clear is a write-time request, never stored.
    assign clr_req = wr & wdata[B_CLR];

    // Assemble the read-back word; unlisted bits stay zero.
    always_comb begin
        word                    = '0;
        word[B_EN]              = cfg.en;
        word[B_IE]              = cfg.ie;
        word[B_OVF]             = ovf;
        word[B_CMODE +: 3]      = cfg.cmode;
        word[B_SMODE +: 3]      = cfg.smode;
        word[B_FILT  +: 3]      = cfg.filt;
        word[B_STALL +: 3]      = cfg.stall;
        word[B_SELB  +: SEL_W]  = cfg.sel_b;
        word[B_SELA  +: SEL_W]  = cfg.sel_a;
    end

    assign unused_bits = ^{wdata[31:30], wdata[23:22], wdata[B_OVF]};

endmodule

// File: rtl/pmc_event_sel.sv
// Module: event picker and combiner.
// Picks two lines from the event bus by index (index 0 or an index beyond
// the bus means no event), then combines them by the combine mode. Purely
// combinational; undefined mode values yield no hit.
module pmc_event_sel
    import pmc_pkg::*;
#(
    parameter int unsigned EVT_W = 64
) (
    input  logic [EVT_W-1:0] evt,
    input  logic [SEL_W-1:0] sel_a,
    input  logic [SEL_W-1:0] sel_b,
    input  logic [2:0]       mode,
    output logic             hit
);

    localparam int unsigned LANES = 2;

    logic [SEL_W-1:0] sel [LANES];
    logic [LANES-1:0] pick;

    assign sel[0] = sel_a;
    assign sel[1] = sel_b;

    // One selector lane per chosen event.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        // Select the event line, with index 0 reserved for "none".
        always_comb begin
            pick[g] = 1'b0;
            for (int i = 1; i < EVT_W; i++) begin
                if (int'(sel[g]) == i) pick[g] = evt[i];
            end
        end
    end

    // Combine the two picked events according to the mode.
    always_comb begin
        case (mode)
            CM_FIRST:  hit = pick[0];
            CM_BOTH:   hit = pick[0] & pick[1];
            CM_EITHER: hit = pick[0] ^ pick[1];
            default:   hit = 1'b0;
        endcase
    end

endmodule

// File: rtl/pmc_counter.sv
// Module: main counter with sticky overflow.
// Advances by one per increment request. Outside ceiling mode it wraps at
// all-ones and flags overflow; in ceiling mode it stops at the ceiling and
// flags overflow on any request made there. Clear wins over everything.
module pmc_counter #(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    input  logic             ceil_en,
    input  logic [CNT_W-1:0] ceil_val,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] cnt_plus,
    output logic             stepped,
    output logic             ovf
);

    localparam logic [CNT_W-1:0] ALL_ONES = '1;

    logic step;
    logic ovf_set;

    assign cnt_plus = cnt + 1'b1;

    // Decide whether this request advances the count or flags overflow.
    always_comb begin
        step    = 1'b0;
        ovf_set = 1'b0;
        if (inc) begin
            if (ceil_en) begin
                if (cnt >= ceil_val) ovf_set = 1'b1;
                else                 step    = 1'b1;
            end else begin
                step    = 1'b1;
                ovf_set = (cnt == ALL_ONES);
            end
        end
    end

    assign stepped = step & ~clr;

    // Count register and sticky overflow.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt <= '0;
            ovf <= 1'b0;
        end else begin
            if (step)    cnt <= cnt_plus;
            if (ovf_set) ovf <= 1'b1;
        end
    end

endmodule

// File: rtl/pmc_secondary.sv
// Module: secondary register.
// Held at zero, loaded with the counter's upper half on each increment, or
// kept as a software-written value (ceiling). A snapshot load wins over a
// same-cycle software write.
module pmc_secondary
    import pmc_pkg::*;
#(
    parameter int unsigned CNT_W  = 32,
    parameter int unsigned HALF_W = CNT_W / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        mode,
    input  logic              stepped,
    input  logic [HALF_W-1:0] snap,
    input  logic              wr,
    input  logic [CNT_W-1:0]  wdata,
    output logic [CNT_W-1:0]  sec
);

    logic [CNT_W-1:0] snap_ext;

    // Zero-extend the snapshot into the register width.
    always_comb begin
        snap_ext             = '0;
        snap_ext[HALF_W-1:0] = snap;
    end

    // Update the secondary register according to its role.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sec <= '0;
        end else begin
            case (mode)
                SM_ZERO: sec <= '0;
                SM_SNAP: begin
                    if (stepped)  sec <= snap_ext;
                    else if (wr)  sec <= wdata;
                end
                default: if (wr) sec <= wdata;
            endcase
        end
    end

endmodule

// File: rtl/perf_event_counter.sv
// Module: dual-event performance monitor counter (top).
// Decodes the register port, wires the control register, event picker,
// main counter and secondary register, and drives the level interrupt.
// Assumes CNT_W is even and at most 32, and EVT_W at most 64.
module perf_event_counter
    import pmc_pkg::*;
#(
    parameter int unsigned EVT_W = 64,
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [EVT_W-1:0] evt_i,
    input  logic             bus_wr,
    input  logic [1:0]       bus_addr,
    input  logic [31:0]      bus_wdata,
    output logic [31:0]      bus_rdata,
    output logic             irq
);

    localparam int unsigned HALF_W = CNT_W / 2;
    localparam logic [1:0]  A_CTRL = 2'd0;
    localparam logic [1:0]  A_CNT  = 2'd1;
    localparam logic [1:0]  A_SEC  = 2'd2;

    pmc_cfg_t          cfg;
    logic              clr_req;
    logic [CTRL_W-1:0] ctrl_word;
    logic              hit;
    logic              inc;
    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  cnt_plus;
    logic              stepped;
    logic              ovf_q;
    logic [CNT_W-1:0]  sec_q;
    logic              wr_ctrl;
    logic              wr_sec;

    assign wr_ctrl = bus_wr & (bus_addr == A_CTRL);
    assign wr_sec  = bus_wr & (bus_addr == A_SEC);

    pmc_ctrl_reg u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (wr_ctrl),
        .wdata   (bus_wdata),
        .ovf     (ovf_q),
        .cfg     (cfg),
        .clr_req (clr_req),
        .word    (ctrl_word)
    );

    pmc_event_sel #(.EVT_W(EVT_W)) u_sel (
        .evt   (evt_i),
        .sel_a (cfg.sel_a),
        .sel_b (cfg.sel_b),
        .mode  (cfg.cmode),
        .hit   (hit)
    );

    assign inc = cfg.en & hit;

    pmc_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr_req),
        .inc      (inc),
        .ceil_en  (cfg.smode == SM_CEIL),
        .ceil_val (sec_q),
        .cnt      (cnt_q),
        .cnt_plus (cnt_plus),
        .stepped  (stepped),
        .ovf      (ovf_q)
    );

    pmc_secondary #(.CNT_W(CNT_W), .HALF_W(HALF_W)) u_sec (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode    (cfg.smode),
        .stepped (stepped),
        .snap    (cnt_plus[CNT_W-1:HALF_W]),
        .wr      (wr_sec),
        .wdata   (bus_wdata[CNT_W-1:0]),
        .sec     (sec_q)
    );

    // Read mux; narrow registers are zero-extended.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_CTRL:  bus_rdata = ctrl_word;
            A_CNT:   bus_rdata[CNT_W-1:0] = cnt_q;
            A_SEC:   bus_rdata[CNT_W-1:0] = sec_q;
            default: bus_rdata = '0;
        endcase
    end

    assign irq = ovf_q & cfg.ie;

endmodule

// File: rtl/pmc_checker.sv
// Module: property checker for perf_event_counter, bound to every instance.
// Observes the counter, overflow, secondary register and interrupt.
module pmc_checker #(
    parameter int unsigned CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             clr,
    input logic             en,
    input logic             ie,
    input logic [2:0]       smode,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] sec,
    input logic             ovf,
    input logic             irq
);

    AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt == '0) && !ovf);                                     // R8

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ovf && !clr |=> ovf);                                             // R6

    AST_UNIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> (cnt == $past(cnt)) || (cnt == $past(cnt) + 1'b1));       // R5

    AST_HOLD_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        !en && !clr |=> $stable(cnt));                                    // R3

    AST_CEILING_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (smode == 3'b011) && (cnt <= sec) && !clr |=> cnt <= $past(sec));  // R10

    AST_SEC_ZEROED: assert property (@(posedge clk) disable iff (!rst_n)
        (smode == 3'b000) |=> sec == '0);                                 // R11

    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        !ie |-> !irq);                                                    // R7

    AST_IRQ_NEEDS_OVF: assert property (@(posedge clk) disable iff (!rst_n)
        !ovf |-> !irq);                                                   // R7

endmodule

bind perf_event_counter pmc_checker #(.CNT_W(CNT_W)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (clr_req),
    .en    (cfg.en),
    .ie    (cfg.ie),
    .smode (cfg.smode),
    .cnt   (cnt_q),
    .sec   (sec_q),
    .ovf   (ovf_q),
    .irq   (irq)
);

// File: tb/sim_perf_event_counter.sv
`timescale 1ns/1ps
// Bench: directed corner cases plus seeded random traffic, all checked
// against a requirement-level model kept in bench variables. The counter is
// narrowed to 16 bits so that a wrap fits in the run.
module sim_perf_event_counter;

    localparam int unsigned CW = 16;
    localparam logic [31:0] WMASK = 32'h3F3F_FFF5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] evt = '0;
    logic        wr = 1'b0;
    logic [1:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int unsigned n_chk = 0;
    int unsigned n_bad = 0;
    bit          done = 1'b0;

    // Model state
    logic [31:0]   m_ctrl = '0;
    logic [CW-1:0] m_cnt  = '0;
    logic [CW-1:0] m_sec  = '0;
    logic          m_ovf  = 1'b0;

    always #2.5 clk = ~clk;

    perf_event_counter #(.EVT_W(64), .CNT_W(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .evt_i(evt), .bus_wr(wr),
        .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata), .irq(irq)
    );

    function automatic logic [31:0] exp_ctrl();
        return (m_ctrl & WMASK) | {28'd0, m_ovf, 3'd0};
    endfunction

    function automatic logic pick(input logic [63:0] ev, input logic [5:0] s);
        return (s != 0) && ev[s];
    endfunction

    function automatic logic hit_of(input logic [63:0] ev);
        logic a, b;
        a = pick(ev, m_ctrl[29:24]);
        b = pick(ev, m_ctrl[21:16]);
        case (m_ctrl[6:4])
            3'd0: return a;
            3'd1: return a & b;
            3'd2: return a ^ b;
            default: return 1'b0;
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
        end
    endtask

    // One clock edge with the given inputs; the model advances alongside.
    task automatic cyc(input logic [63:0] ev, input logic w, input logic [1:0] a,
                       input logic [31:0] d);
        logic [CW-1:0] n_cnt, n_sec;
        logic n_ovf, inc, clr, stp;
        logic [2:0] sm;
        @(negedge clk);
        evt = ev; wr = w; addr = a; wdata = d;
        sm = m_ctrl[9:7];
        inc = m_ctrl[0] && hit_of(ev);
        clr = w && (a == 2'd0) && d[1];
        n_cnt = m_cnt; n_sec = m_sec; n_ovf = m_ovf; stp = 1'b0;
        if (clr) begin
            n_cnt = '0; n_ovf = 1'b0;
        end else if (inc) begin
            if (sm == 3'b011) begin
                if (m_cnt >= m_sec) n_ovf = 1'b1;
                else begin n_cnt = m_cnt + 1'b1; stp = 1'b1; end
            end else begin
                if (m_cnt == '1) n_ovf = 1'b1;
                n_cnt = m_cnt + 1'b1; stp = 1'b1;
            end
        end
        if (sm == 3'b000) n_sec = '0;
        else if (sm == 3'b001 && stp) n_sec = {8'd0, n_cnt[15:8]};
        else if (w && a == 2'd2) n_sec = d[CW-1:0];
        @(posedge clk);
        m_cnt = n_cnt; m_sec = n_sec; m_ovf = n_ovf;
        if (w && a == 2'd0) m_ctrl = d & WMASK;
    endtask

    task automatic idle(); cyc('0, 1'b0, 2'd0, '0); endtask
    task automatic wctl(input logic [31:0] d); cyc('0, 1'b1, 2'd0, d); endtask
    task automatic wsec(input logic [31:0] d); cyc('0, 1'b1, 2'd2, d); endtask

    function automatic logic [31:0] mk(input logic [5:0] sa, input logic [5:0] sb,
                                       input logic [2:0] sm, input logic [2:0] cm,
                                       input logic ie, input logic en);
        return {2'b0, sa, 2'b0, sb, 6'd0, sm, cm, 1'b0, ie, 1'b0, en};
    endfunction

    // Read one address between edges.
    task automatic peek(input logic [1:0] a, output logic [31:0] v);
        addr = a; wr = 1'b0; evt = '0;
        #0.4;
        v = rdata;
    endtask

    // Compare every visible register and the interrupt with the model.
    task automatic check_all(input string req);
        logic [31:0] v;
        @(negedge clk);
        peek(2'd0, v); check({req, "/R12 ctrl"}, v, exp_ctrl());
        peek(2'd1, v); check({req, "/R3 count"}, v, {16'd0, m_cnt});
        peek(2'd2, v); check({req, "/R9 secondary"}, v, {16'd0, m_sec});
        check({req, "/R7 irq"}, {31'd0, irq}, {31'd0, m_ovf & m_ctrl[2]});
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
            $finish;
        end
    endtask

    // Watchdog
    initial begin
        repeat (190000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'd24601));
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R1: reset state
        check_all("R1");

        // R12: reserved and clear bits read zero, ovf not writable
        wctl(32'hFFFF_FFFF);
        @(negedge clk); peek(2'd0, v); check("R12 reserved", v, 32'h3F3F_FFF5);
        wctl(mk(0, 0, 3'd0, 3'd0, 0, 0) | 32'h0000_FC00);
        @(negedge clk); peek(2'd0, v); check("R12 filter/stall", v, 32'h0000_FC00);
        wctl(32'd0);

        // R2: selector 0 never counts; selector 63 picks line 63
        wctl(mk(0, 0, 3'd0, 3'd0, 0, 1));
        repeat (5) cyc('1, 0, 0, 0);
        check_all("R2 sel0");
        wctl(mk(63, 0, 3'd0, 3'd0, 0, 1));
        repeat (4) cyc(64'h8000_0000_0000_0000, 0, 0, 0);
        repeat (3) cyc(64'h4000_0000_0000_0000, 0, 0, 0);
        @(negedge clk); peek(2'd1, v); check("R2 sel63", v, 32'd4);

        // R3: disabled counter holds
        wctl(mk(63, 0, 3'd0, 3'd0, 0, 0));
        repeat (4) cyc('1, 0, 0, 0);
        @(negedge clk); peek(2'd1, v); check("R3 hold", v, 32'd4);

        // R4: both / exactly one / undefined mode
        wctl(mk(3, 5, 3'd0, 3'd1, 0, 1) | 32'h2);
        cyc(64'h08, 0, 0, 0); cyc(64'h28, 0, 0, 0); cyc(64'h20, 0, 0, 0); cyc(64'h28, 0, 0, 0);
        @(negedge clk); peek(2'd1, v); check("R4 both", v, 32'd2);
        wctl(mk(3, 5, 3'd0, 3'd2, 0, 1) | 32'h2);
        cyc(64'h08, 0, 0, 0); cyc(64'h28, 0, 0, 0); cyc(64'h20, 0, 0, 0); cyc(64'h00, 0, 0, 0);
        @(negedge clk); peek(2'd1, v); check("R4 xor", v, 32'd2);
        wctl(mk(3, 5, 3'd0, 3'd5, 0, 1) | 32'h2);
        repeat (3) cyc('1, 0, 0, 0);
        @(negedge clk); peek(2'd1, v); check("R4 undefined", v, 32'd0);

        // R13: counter write ignored, address 3 reads zero
        cyc('0, 1, 2'd1, 32'h1234);
        @(negedge clk); peek(2'd1, v); check("R13 cnt write", v, 32'd0);
        peek(2'd3, v); check("R13 addr3", v, 32'd0);

        // R11: secondary held at zero in mode 0
        wctl(mk(1, 0, 3'd0, 3'd0, 0, 0));
        wsec(32'h55);
        @(negedge clk); peek(2'd2, v); check("R11 sec zero", v, 32'd0);

        // R10: ceiling stops the count and flags overflow
        wctl(mk(1, 0, 3'd3, 3'd0, 1, 1) | 32'h2);
        wsec(32'd10);
        repeat (9) cyc(64'h2, 0, 0, 0);
        check_all("R10 below");
        repeat (6) cyc(64'h2, 0, 0, 0);
        check_all("R10 ceiling");
        @(negedge clk); peek(2'd1, v); check("R10 stop", v, 32'd10);
        check("R7 irq on", {31'd0, irq}, 32'd1);

        // R8: clear zeroes count and status
        wctl(mk(1, 0, 3'd3, 3'd0, 1, 1) | 32'h2);
        @(negedge clk); peek(2'd1, v); check("R8 count", v, 32'd0);
        peek(2'd0, v); check("R8 ovf/clr bits", v & 32'hA, 32'd0);

        // R5/R6: wrap at all-ones, sticky afterwards
        wctl(mk(1, 0, 3'd2, 3'd0, 0, 1) | 32'h2);
        repeat (65535) cyc(64'h2, 0, 0, 0);
        check_all("R5 top");
        cyc(64'h2, 0, 0, 0);
        check_all("R5 wrap");
        repeat (7) cyc(64'h2, 0, 0, 0);
        wctl(mk(1, 0, 3'd2, 3'd0, 1, 1));
        check_all("R6 sticky");

        // R9: snapshot of upper half
        wctl(mk(1, 0, 3'd1, 3'd0, 0, 1) | 32'h2);
        repeat (300) cyc(64'h2, 0, 0, 0);
        check_all("R9 snap");
        @(negedge clk); peek(2'd2, v); check("R9 value", v, 32'd1);

        // Random traffic against the model
        for (int i = 0; i < 3000; i++) begin
            logic [63:0] ev;
            int unsigned r;
            ev = {$urandom, $urandom};
            r  = $urandom % 16;
            if (r == 0) begin
                logic [2:0] sm;
                sm = ($urandom % 4 == 2) ? 3'd0 : 3'($urandom % 4);
                cyc(ev, 1, 2'd0,
                    mk(6'($urandom % 8), 6'($urandom % 8), sm, 3'($urandom % 4),
                       1'($urandom), 1'($urandom % 4 != 0))
                    | (($urandom % 8 == 0) ? 32'h2 : 32'h0));
            end else if (r == 1) begin
                cyc(ev, 1, 2'd2, $urandom % 64);
            end else begin
                cyc(ev, 0, 2'd0, '0);
            end
            if (i % 8 == 0) check_all("R3 random");
        end
        check_all("R4 random end");

        finish_run();
    end

endmodule